// File: doc/BRIEF.md
# Field-Encoded Microprogrammed Controller

This block sequences the control strobes of a single-bus processor datapath. A microprogram counter addresses a small constant control store. Each store word packs its control information into binary-coded fields: one bus source, two load targets, an ALU function, a memory command, an operand select, a wait flag and an end flag. A field decoder expands the word into individual strobes, one wire per datapath action. The outputs are combinational functions of the counter, so every strobe belongs to the microinstruction held in the counter during that cycle.

Every instruction starts with a shared three-word fetch routine. The fourth word dispatches on the opcode supplied by the instruction register. There are four routines: a register add (R1 += R2), a memory-indirect add (R1 += [R3]), a branch-if-negative, and a safe routine for any other opcode that only ends. A word with the wait flag set holds the counter until memory signals completion. The branch routine tests the N condition code and returns to fetch when N is clear.

Top module: `ucode_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the controller presents fetch word 0. That word drives `src_oe[0]` (PC out), `lda[2]` (Z load), `ldb[0]` (MAR load), `mem_rd`, `sel4` and `alu_fn`=0000 (add). Every other strobe is low.
- R2: Fetch runs in three cycles. Word 0 is followed by word 1: `src_oe[2]` (Z out), `lda[0]` (PC load), `ldb[3]` (Y load) and `wmfc`. Word 2 follows: `src_oe[1]` (MDR out) and `lda[1]` (IR load).
- R3: While `wmfc` is high and `mfc` is low at a clock edge, all strobes hold their values. The counter advances at the first edge where `mfc` is high.
- R4: The word after fetch is a dispatch word with no strobes active. Opcode 00 then runs three words. The first is `src_oe[5]` (R2 out) with `ldb[3]`. The second is `src_oe[4]` (R1 out), `lda[2]`, add with select-Y. The third is `src_oe[2]`, `lda[4]` (R1 load) and `done`.
- R5: Opcode 01 runs four words. The first is `src_oe[6]` (R3 out), `ldb[0]` and `mem_rd`. The second is `src_oe[4]`, `ldb[3]` and `wmfc`. The third is `src_oe[1]` with `lda[2]`. The fourth is `src_oe[2]`, `lda[4]` and `done`.
- R6: Opcode 10 first presents a test word with no strobes active. If `n_flag` is 0 at the next edge, fetch word 0 follows.
- R7: With opcode 10 and `n_flag` at 1, two words follow. The first is `src_oe[8]` (offset out), `lda[2]`, add with select-Y. The second is `src_oe[2]`, `lda[0]` and `done`.
- R8: Opcode 11 runs a single word with only `done` active.
- R9: The cycle after any word with `done` active presents fetch word 0.
- R10: At most one bit of `src_oe`, at most one of `lda` and at most one of `ldb` is active at a time. `mem_rd` and `mem_wr` are never both high.
- R11: `n_flag` has no effect outside the test word. `opcode` has no effect outside the dispatch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | OPW | Opcode field of the instruction register |
| n_flag | input | 1 | Negative condition code |
| mfc | input | 1 | Memory function complete |
| src_oe | output | 9 | Bus source enables: PC, MDR, Z, R0–R3, TEMP, offset (bits 0..8) |
| lda | output | 7 | First load group: PC, IR, Z, R0–R3 (bits 0..6) |
| ldb | output | 4 | Second load group: MAR, MDR, TEMP, Y (bits 0..3) |
| alu_fn | output | 4 | ALU function code, 0000 = add |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| sel4 | output | 1 | ALU A-input select: 1 = constant 4, 0 = Y |
| wmfc | output | 1 | Wait-for-memory flag of the current word |
| done | output | 1 | End of instruction |

## Verification
All strobes decode combinationally from the counter. After any edge, the new word can therefore be seen in the same cycle, one edge after the condition that selected it. This covers reset release, the `mfc` pulse, the dispatch and the `n_flag` test. The bench drives `mfc`, `n_flag` and `opcode` on the falling edge before the deciding rising edge. It compares the whole strobe vector on the falling edge of each following cycle. Each stall cycle therefore gets its own comparison against the held word, and the word that comes after the release edge is compared exactly once.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
   localparam int NREG  = 4;
   localparam int SRC_W = 9;
   localparam int LDA_W = 7;
   localparam int LDB_W = 4;

   // bus source field
   localparam logic [3:0] S_NONE = 4'b0000, S_PC = 4'b0001, S_MDR = 4'b0010,
                          S_Z = 4'b0011, S_R0 = 4'b0100, S_R1 = 4'b0101,
                          S_R2 = 4'b0110, S_R3 = 4'b0111, S_TEMP = 4'b1010,
                          S_OFS = 4'b1011;
   // first load field
   localparam logic [2:0] A_NONE = 3'b000, A_PC = 3'b001, A_IR = 3'b010,
                          A_Z = 3'b011, A_R1 = 3'b101;
   // second load field
   localparam logic [2:0] B_NONE = 3'b000, B_MAR = 3'b001, B_Y = 3'b100;
   localparam logic [3:0] ALU_ADD = 4'b0000;
   localparam logic [1:0] M_NONE = 2'b00, M_RD = 2'b01, M_WR = 2'b10;
   // sequencing field
   localparam logic [1:0] Q_NEXT = 2'b00, Q_DISP = 2'b01, Q_BRN = 2'b10;

   // routine entry points
   localparam logic [3:0] RT_RADD = 4'd4, RT_MADD = 4'd7, RT_BRN = 4'd11,
                          RT_UNDEF = 4'd14;

   typedef struct packed {
      logic [1:0] seq;
      logic       fin;
      logic       wt;
      logic       sel;
      logic [1:0] mem;
      logic [3:0] alu;
      logic [2:0] ldb;
      logic [2:0] lda;
      logic [3:0] src;
   } uword_t;

   function automatic uword_t mk(logic [3:0] src, logic [2:0] lda, logic [2:0] ldb,
                                 logic [1:0] mem, logic sel, logic wt, logic fin,
                                 logic [1:0] seq);
      uword_t w;
      w.src = src; w.lda = lda; w.ldb = ldb; w.alu = ALU_ADD; w.mem = mem;
      w.sel = sel; w.wt = wt; w.fin = fin; w.seq = seq;
      return w;
   endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
   import ucode_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic [AW-1:0] addr,
   output uword_t        word
);
   logic in_rng;

   generate
      if (AW == 4) begin : g_exact
         assign in_rng = 1'b1;
      end else begin : g_wide
         assign in_rng = (addr[AW-1:4] == '0);
      end
   endgenerate

   always_comb begin
      word = mk(S_NONE, A_NONE, B_NONE, M_NONE, 1'b0, 1'b0, 1'b1, Q_NEXT);
      if (in_rng) begin
         case (addr[3:0])
            4'd0:  word = mk(S_PC,   A_Z,    B_MAR,  M_RD,   1'b1, 1'b0, 1'b0, Q_NEXT);
            4'd1:  word = mk(S_Z,    A_PC,   B_Y,    M_NONE, 1'b0, 1'b1, 1'b0, Q_NEXT);
            4'd2:  word = mk(S_MDR,  A_IR,   B_NONE, M_NONE, 1'b0, 1'b0, 1'b0, Q_NEXT);
            4'd3:  word = mk(S_NONE, A_NONE, B_NONE, M_NONE, 1'b0, 1'b0, 1'b0, Q_DISP);
            4'd4:  word = mk(S_R2,   A_NONE, B_Y,    M_NONE, 1'b0, 1'b0, 1'b0, Q_NEXT);
            4'd5:  word = mk(S_R1,   A_Z,    B_NONE, M_NONE, 1'b0, 1'b0, 1'b0, Q_NEXT);
            4'd6:  word = mk(S_Z,    A_R1,   B_NONE, M_NONE, 1'b0, 1'b0, 1'b1, Q_NEXT);
            4'd7:  word = mk(S_R3,   A_NONE, B_MAR,  M_RD,   1'b0, 1'b0, 1'b0, Q_NEXT);
            4'd8:  word = mk(S_R1,   A_NONE, B_Y,    M_NONE, 1'b0, 1'b1, 1'b0, Q_NEXT);
            4'd9:  word = mk(S_MDR,  A_Z,    B_NONE, M_NONE, 1'b0, 1'b0, 1'b0, Q_NEXT);
            4'd10: word = mk(S_Z,    A_R1,   B_NONE, M_NONE, 1'b0, 1'b0, 1'b1, Q_NEXT);
            4'd11: word = mk(S_NONE, A_NONE, B_NONE, M_NONE, 1'b0, 1'b0, 1'b0, Q_BRN);
            4'd12: word = mk(S_OFS,  A_Z,    B_NONE, M_NONE, 1'b0, 1'b0, 1'b0, Q_NEXT);
            4'd13: word = mk(S_Z,    A_PC,   B_NONE, M_NONE, 1'b0, 1'b0, 1'b1, Q_NEXT);
            default: word = mk(S_NONE, A_NONE, B_NONE, M_NONE, 1'b0, 1'b0, 1'b1, Q_NEXT);
         endcase
      end
   end
endmodule

// File: rtl/ucode_fdec.sv
module ucode_fdec
   import ucode_pkg::*;
(
   input  logic [3:0]       f_src,
   input  logic [2:0]       f_lda,
   input  logic [2:0]       f_ldb,
   input  logic [3:0]       f_alu,
   input  logic [1:0]       f_mem,
   input  logic             f_sel,
   output logic [SRC_W-1:0] src_oe,
   output logic [LDA_W-1:0] lda,
   output logic [LDB_W-1:0] ldb,
   output logic [3:0]       alu_fn,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             sel4
);
   assign src_oe[0] = (f_src == S_PC);
   assign src_oe[1] = (f_src == S_MDR);
   assign src_oe[2] = (f_src == S_Z);
   assign src_oe[7] = (f_src == S_TEMP);
   assign src_oe[8] = (f_src == S_OFS);
   assign lda[0]    = (f_lda == A_PC);
   assign lda[1]    = (f_lda == A_IR);
   assign lda[2]    = (f_lda == A_Z);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [1:0] IX = 2'(g);
      assign src_oe[3+g] = (f_src == {2'b01, IX});
      assign lda[3+g]    = (f_lda == {1'b1, IX});
   end

   for (genvar g = 0; g < LDB_W; g++) begin : g_ldb
      assign ldb[g] = (f_ldb == 3'(g + 1));
   end

   assign alu_fn = f_alu;
   assign mem_rd = (f_mem == M_RD);
   assign mem_wr = (f_mem == M_WR);
   assign sel4   = f_sel;
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_pkg::*;
#(
   parameter int AW  = 4,
   parameter int OPW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [OPW-1:0] opcode,
   input  logic           n_flag,
   input  logic           mfc,
   input  logic [1:0]     f_seq,
   input  logic           f_wt,
   input  logic           f_fin,
   output logic [AW-1:0]  upc
);
   logic [AW-1:0] start, nxt;

   always_comb begin
      if (opcode == OPW'(0))      start = AW'(RT_RADD);
      else if (opcode == OPW'(1)) start = AW'(RT_MADD);
      else if (opcode == OPW'(2)) start = AW'(RT_BRN);
      else                        start = AW'(RT_UNDEF);
   end

   always_comb begin
      if (f_wt && !mfc)                  nxt = upc;
      else if (f_fin)                    nxt = '0;
      else if (f_seq == Q_DISP)          nxt = start;
      else if (f_seq == Q_BRN && !n_flag) nxt = '0;
      else                               nxt = upc + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) upc <= '0;
      else        upc <= nxt;
   end
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
   import ucode_pkg::*;
#(
   parameter int AW  = 4,
   parameter int OPW = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPW-1:0]   opcode,
   input  logic             n_flag,
   input  logic             mfc,
   output logic [SRC_W-1:0] src_oe,
   output logic [LDA_W-1:0] lda,
   output logic [LDB_W-1:0] ldb,
   output logic [3:0]       alu_fn,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             sel4,
   output logic             wmfc,
   output logic             done
);
   generate
      if (AW < 4) begin : g_bad_aw
         $error("ucode_ctrl: AW must be at least 4");
      end
      if (OPW < 2) begin : g_bad_opw
         $error("ucode_ctrl: OPW must be at least 2");
      end
   endgenerate

   logic [AW-1:0] upc;
   uword_t        word;

   ucode_rom #(.AW(AW)) u_rom (.addr(upc), .word(word));

   ucode_seq #(.AW(AW), .OPW(OPW)) u_seq (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .n_flag(n_flag), .mfc(mfc),
      .f_seq(word.seq), .f_wt(word.wt), .f_fin(word.fin), .upc(upc));

   ucode_fdec u_dec (
      .f_src(word.src), .f_lda(word.lda), .f_ldb(word.ldb), .f_alu(word.alu),
      .f_mem(word.mem), .f_sel(word.sel), .src_oe(src_oe), .lda(lda), .ldb(ldb),
      .alu_fn(alu_fn), .mem_rd(mem_rd), .mem_wr(mem_wr), .sel4(sel4));

   assign wmfc = word.wt;
   assign done = word.fin;
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mfc,
   input logic [8:0] src_oe,
   input logic [6:0] lda,
   input logic [3:0] ldb,
   input logic [3:0] alu_fn,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       sel4,
   input logic       wmfc,
   input logic       done
);
   AST_SRC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_oe)); // R10
   AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lda) && $onehot0(ldb)); // R10
   AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R10
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wmfc && !mfc) |=> ($stable(src_oe) && $stable(lda) && $stable(ldb) &&
                          $stable(mem_rd) && $stable(wmfc) && $stable(done))); // R3
   AST_END_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (src_oe == 9'h001 && mem_rd && sel4 && !done)); // R9
   AST_IR_THEN_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      lda[1] |=> (src_oe == '0 && lda == '0 && ldb == '0)); // R4
   AST_ALU_ADD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      lda[2] |-> (alu_fn == 4'b0000)); // R1
endmodule

bind ucode_ctrl ucode_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mfc(mfc), .src_oe(src_oe), .lda(lda), .ldb(ldb),
   .alu_fn(alu_fn), .mem_rd(mem_rd), .mem_wr(mem_wr), .sel4(sel4),
   .wmfc(wmfc), .done(done));

// File: tb/sim_ucode_ctrl.sv
`timescale 1ns/1ps
module sim_ucode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] opcode = 2'b00;
   logic       n_flag = 1'b0;
   logic       mfc = 1'b0;
   logic [8:0] src_oe;
   logic [6:0] lda;
   logic [3:0] ldb, alu_fn;
   logic       mem_rd, mem_wr, sel4, wmfc, done;
   int         n_chk = 0, n_bad = 0;

   // {src_oe, lda, ldb, alu_fn, rd, wr, sel4, wmfc, done}
   localparam logic [28:0] W0 = {9'h001, 7'h04, 4'h1, 4'h0, 5'b10100};
   localparam logic [28:0] W1 = {9'h004, 7'h01, 4'h8, 4'h0, 5'b00010};
   localparam logic [28:0] W2 = {9'h002, 7'h02, 4'h0, 4'h0, 5'b00000};
   localparam logic [28:0] WZ = '0;
   localparam logic [28:0] A1 = {9'h020, 7'h00, 4'h8, 4'h0, 5'b00000};
   localparam logic [28:0] A2 = {9'h010, 7'h04, 4'h0, 4'h0, 5'b00000};
   localparam logic [28:0] A3 = {9'h004, 7'h10, 4'h0, 4'h0, 5'b00001};
   localparam logic [28:0] B1 = {9'h040, 7'h00, 4'h1, 4'h0, 5'b10000};
   localparam logic [28:0] B2 = {9'h010, 7'h00, 4'h8, 4'h0, 5'b00010};
   localparam logic [28:0] B3 = {9'h002, 7'h04, 4'h0, 4'h0, 5'b00000};
   localparam logic [28:0] C1 = {9'h100, 7'h04, 4'h0, 4'h0, 5'b00000};
   localparam logic [28:0] C2 = {9'h004, 7'h01, 4'h0, 4'h0, 5'b00001};
   localparam logic [28:0] U1 = {9'h000, 7'h00, 4'h0, 4'h0, 5'b00001};

   ucode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .n_flag(n_flag), .mfc(mfc),
      .src_oe(src_oe), .lda(lda), .ldb(ldb), .alu_fn(alu_fn), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .sel4(sel4), .wmfc(wmfc), .done(done));

   always #4 clk = ~clk;

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [28:0] exp);
      logic [28:0] obs;
      obs = {src_oe, lda, ldb, alu_fn, mem_rd, mem_wr, sel4, wmfc, done};
      n_chk++;
      if (obs !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, obs, exp);
      end
   endtask

   task automatic chk_excl();
      n_chk++;
      if ($countones(src_oe) > 1 || $countones(lda) > 1 || $countones(ldb) > 1 ||
          (mem_rd && mem_wr)) begin
         n_bad++;
         $display("FAIL R10: src %h lda %h ldb %h rd %b wr %b, expected single", src_oe,
                  lda, ldb, mem_rd, mem_wr);
      end
   endtask

   // from word 0: fetch with a stall, ends presenting dispatch word
   task automatic t_fetch(input logic [1:0] op, input int stall);
      opcode = op;
      chk("R2", W0);
      chk_excl();
      step(); chk("R2", W1);
      for (int i = 0; i < stall; i++) begin
         step(); chk("R3", W1);
      end
      mfc = 1'b1;
      step(); mfc = 1'b0;
      chk("R2", W2);
      step(); chk("R4", WZ);
   endtask

   task automatic t_radd();
      step(); chk("R4", A1);
      n_flag = ~n_flag; opcode = 2'b10;   // R11: no effect here
      step(); chk("R11", A2);
      chk_excl();
      step(); chk("R4", A3);
      step(); chk("R9", W0);
   endtask

   task automatic t_madd();
      step(); chk("R5", B1);
      step(); chk("R5", B2);
      step(); chk("R3", B2);
      step(); chk("R3", B2);
      mfc = 1'b1;
      step(); mfc = 1'b0;
      chk("R5", B3);
      step(); chk("R5", A3);
      step(); chk("R9", W0);
   endtask

   task automatic t_brn(input logic n);
      step(); chk("R6", WZ);
      n_flag = n;
      step();
      if (!n) chk("R6", W0);
      else begin
         chk("R7", C1);
         n_flag = ~n_flag;                // R11: ignored after test
         step(); chk("R7", C2);
         step(); chk("R9", W0);
      end
   endtask

   task automatic t_undef();
      step(); chk("R8", U1);
      step(); chk("R9", W0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", W0);
      rst_n = 1'b1;
      chk("R1", W0);
      t_fetch(2'b00, 2); t_radd();
      t_fetch(2'b01, 0); t_madd();
      t_fetch(2'b10, 1); t_brn(1'b0);
      t_fetch(2'b10, 0); t_brn(1'b1);
      t_fetch(2'b11, 3); t_undef();
      n_flag = 1'b1;
      t_fetch(2'b00, 0); t_radd();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule